// File: doc/BRIEF.md
# Spiking Margin-Propagation Network

This block is a clocked network of three integrate-and-fire cells that works on 1-bit spike streams. Two input cells each take one input stream. A third cell, the constraint cell, takes a budget stream. Every cell holds a signed membrane. On each enabled clock step the membrane moves by a programmable step size times the number of exciting spikes minus the number of inhibiting spikes. The new value is then clamped between a programmable floor and ceiling. A cell's output spike for a step is registered, and it is set when the membrane held before that step's update is at or above a programmable firing level.

Each input cell is excited by its own input stream. It is inhibited by its own output spike and by the constraint cell's output `z`. The constraint cell is excited by the output spikes of all input cells and inhibited by the budget stream. Because every membrane stays bounded, each cell's long-run output rate matches its net input rate. The floor clamp turns a negative net drive into a rectified zero rate. The loop therefore settles where the sum of the rectified gaps (input rate minus `z` rate) equals the budget rate, so the `z` rate solves a reverse water-filling constraint. Conversion into and out of the log domain happens outside this block.

Top module: `spike_mp_net`

## Requirements
- R1: With `rst` high at a clock edge, every membrane is loaded with `mem_lo` and every output spike is cleared to 0 at that edge.
- R2: While `en` is low, no membrane and no output spike changes.
- R3: On each enabled step, a membrane changes by `step_alpha` times (number of exciting spikes minus number of inhibiting spikes) in that step, before the clamp is applied.
- R4: An output spike for a step is 1 exactly when the membrane value held before that step's update is greater than or equal to `fire_lvl` (signed compare). The spike is registered, so it appears one edge after the membrane reaches the level.
- R5: Input cell k is excited by `in_spk[k]` and inhibited by both `out_spk[k]` and `z_spk`.
- R6: The constraint cell is excited by every bit of `out_spk` and inhibited by `gamma_spk`, and its spike is `z_spk`.
- R7: After each update a membrane is clamped to the signed range [`mem_lo`, `mem_hi`]. Drive beyond either limit is discarded, so a cell held at the floor always needs the full climb from `mem_lo` to `fire_lvl` before it fires again.
- R8: With step 8, floor -128, ceiling 127, firing level 0, budget rate 0.3 and random input streams, the count of `out_spk[0]` plus `out_spk[1]` spikes over a 4096-step window taken after settling is within 2% of the budget spike count.
- R9: With budget rate 0.3 and input-1 rate 0.5, the `z` rate settles near 0.2 with input-0 rate 0.2, and near 0.25 with input-0 rate 0.3. In both cases the input-1 spike count plus the `z` count stays within 2% of the input-1 count.
- R10: With `step_alpha` equal to 0, membranes never move, so after reset no cell fires while `fire_lvl` is above `mem_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per time step |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable; low freezes all state |
| in_spk | input | NUM_IN | Input spike streams, one bit per input cell |
| gamma_spk | input | 1 | Budget spike stream, inhibits the constraint cell |
| step_alpha | input | 4 | Unsigned membrane step size |
| mem_lo | input | 12 | Signed membrane floor and reset value |
| mem_hi | input | 12 | Signed membrane ceiling |
| fire_lvl | input | 12 | Signed firing level |
| out_spk | output | NUM_IN | Registered spikes of the input cells |
| z_spk | output | 1 | Registered spike of the constraint cell |

## Verification
The hardest condition to reach from the ports is a membrane sitting at its floor while inhibition keeps pushing it down. No membrane is visible, and the only proof that the clamp worked is when the next spike arrives. The bench holds the budget stream high while no input cell fires, so the constraint membrane is driven far below its floor. It then releases a single input and measures the exact step of the first `z` spike, which depends only on the full climb from the floor. Long random runs from LFSR-driven Bernoulli streams are then compared step by step against a behavioural model, and their spike counts are checked against the rate-balance relations.

// File: rtl/mpn_pkg.sv
package mpn_pkg;

    localparam int MEM_W  = 12;
    localparam int STEP_W = 4;
    localparam int ACC_W  = MEM_W + STEP_W + 6;

    typedef logic signed [MEM_W-1:0] mem_t;
    typedef logic        [STEP_W-1:0] step_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        step_t alpha;
        mem_t  lo_lim;
        mem_t  hi_lim;
        mem_t  fire_lvl;
    } cell_cfg_t;

    // Saturate a wide intermediate back into the membrane range.
    function automatic mem_t clamp_mem(acc_t x, mem_t lo, mem_t hi);
        acc_t lo_e;
        acc_t hi_e;
        lo_e = acc_t'(lo);
        hi_e = acc_t'(hi);
        if (x < lo_e)
            return lo;
        else if (x > hi_e)
            return hi;
        else
            return mem_t'(x);
    endfunction

    // Net spike count scaled by the unsigned step size.
    function automatic acc_t scaled_step(step_t a, acc_t net);
        return net * acc_t'({1'b0, a});
    endfunction

endpackage

// File: rtl/mpn_cell.sv
module mpn_cell
    import mpn_pkg::*;
#(
    parameter int N_EXC = 1,
    parameter int N_INH = 2
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [N_EXC-1:0] exc,
    input  logic [N_INH-1:0] inh,
    input  cell_cfg_t        cfg,
    output logic             spike,
    output mem_t             mem
);

    acc_t net;
    acc_t target;

    // Count excitatory minus inhibitory spikes in this step.
    always_comb begin
        net = '0;
        for (int i = 0; i < N_EXC; i++)
            net = net + acc_t'({1'b0, exc[i]});
        for (int j = 0; j < N_INH; j++)
            net = net - acc_t'({1'b0, inh[j]});
    end

    assign target = acc_t'(mem) + scaled_step(cfg.alpha, net);

    // Spike decision uses the membrane held before this update.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem   <= cfg.lo_lim;
            spike <= 1'b0;
        end else if (en) begin
            spike <= ($signed(mem) >= $signed(cfg.fire_lvl));
            mem   <= clamp_mem(target, cfg.lo_lim, cfg.hi_lim);
        end
    end

endmodule

// File: rtl/spike_mp_net.sv
module spike_mp_net
    import mpn_pkg::*;
#(
    parameter int NUM_IN = 2
)
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [NUM_IN-1:0]       in_spk,
    input  logic                    gamma_spk,
    input  logic [STEP_W-1:0]       step_alpha,
    input  logic signed [MEM_W-1:0] mem_lo,
    input  logic signed [MEM_W-1:0] mem_hi,
    input  logic signed [MEM_W-1:0] fire_lvl,
    output logic [NUM_IN-1:0]       out_spk,
    output logic                    z_spk
);

    localparam int N_CELL = NUM_IN + 1;

    cell_cfg_t                     cfg;
    logic [N_CELL-1:0][MEM_W-1:0]  mem_v;

    assign cfg = '{alpha: step_alpha, lo_lim: mem_lo, hi_lim: mem_hi, fire_lvl: fire_lvl};

    // Input cells: excited by their stream, inhibited by self and by z.
    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            mpn_cell #(.N_EXC(1), .N_INH(2)) u_cell (
                .clk   (clk),
                .rst   (rst),
                .en    (en),
                .exc   (in_spk[i]),
                .inh   ({z_spk, out_spk[i]}),
                .cfg   (cfg),
                .spike (out_spk[i]),
                .mem   (mem_v[i])
            );
        end
    endgenerate

    // Constraint cell: excited by all input-cell spikes, inhibited by the budget.
    mpn_cell #(.N_EXC(NUM_IN), .N_INH(1)) u_constraint (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .exc   (out_spk),
        .inh   (gamma_spk),
        .cfg   (cfg),
        .spike (z_spk),
        .mem   (mem_v[NUM_IN])
    );

endmodule

// File: rtl/mpn_net_chk.sv
module mpn_net_chk
    import mpn_pkg::*;
#(
    parameter int NUM_IN = 2
)
(
    input logic                        clk,
    input logic                        rst,
    input logic                        en,
    input logic [NUM_IN-1:0]           in_spk,
    input logic                        gamma_spk,
    input logic [STEP_W-1:0]           step_alpha,
    input logic signed [MEM_W-1:0]     mem_lo,
    input logic signed [MEM_W-1:0]     mem_hi,
    input logic [NUM_IN-1:0]           out_spk,
    input logic                        z_spk,
    input logic [NUM_IN:0][MEM_W-1:0]  mem_v
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_spk == '0 && !z_spk)); // R1

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(out_spk) && $stable(z_spk) && $stable(mem_v))); // R2

    generate
        for (genvar k = 0; k <= NUM_IN; k++) begin : g_rng
            AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
                (en && $signed(mem_lo) <= $signed(mem_hi)) |=>
                ($signed(mem_v[k]) >= $signed($past(mem_lo)) &&
                 $signed(mem_v[k]) <= $signed($past(mem_hi)))); // R7
        end
        for (genvar k = 0; k < NUM_IN; k++) begin : g_inh
            AST_INPUT_INHIB: assert property (@(posedge clk) disable iff (rst)
                (en && out_spk[k] && z_spk && !in_spk[k] && step_alpha != '0 &&
                 $signed(mem_lo) <= $signed(mem_hi)) |=>
                ($signed(mem_v[k]) < $signed($past(mem_v[k])) ||
                 mem_v[k] == $past(mem_lo))); // R5
        end
    endgenerate

    AST_BUDGET_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (en && out_spk == '0 && gamma_spk && step_alpha != '0 &&
         $signed(mem_lo) <= $signed(mem_hi)) |=>
        ($signed(mem_v[NUM_IN]) < $signed($past(mem_v[NUM_IN])) ||
         mem_v[NUM_IN] == $past(mem_lo))); // R6

endmodule

bind spike_mp_net mpn_net_chk #(.NUM_IN(NUM_IN)) u_net_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .in_spk     (in_spk),
    .gamma_spk  (gamma_spk),
    .step_alpha (step_alpha),
    .mem_lo     (mem_lo),
    .mem_hi     (mem_hi),
    .out_spk    (out_spk),
    .z_spk      (z_spk),
    .mem_v      (mem_v)
);

// File: tb/test_spike_mp_net.sv
`timescale 1ns/1ps
module test_spike_mp_net;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic [1:0]        in_spk = '0;
    logic              gamma_spk = 1'b0;
    logic [3:0]        step_alpha = 4'd8;
    logic signed [11:0] mem_lo = -12'sd128;
    logic signed [11:0] mem_hi = 12'sd127;
    logic signed [11:0] fire_lvl = 12'sd0;
    logic [1:0]        out_spk;
    logic              z_spk;

    always #2.5 clk = ~clk;

    spike_mp_net #(.NUM_IN(2)) i_spike_mp_net (
        .clk(clk), .rst(rst), .en(en), .in_spk(in_spk), .gamma_spk(gamma_spk),
        .step_alpha(step_alpha), .mem_lo(mem_lo), .mem_hi(mem_hi), .fire_lvl(fire_lvl),
        .out_spk(out_spk), .z_spk(z_spk)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Behavioural model state: cells 0,1 are input cells, 2 is the constraint cell.
    int mv [3];
    bit ms [3];
    logic [2:0] exp_q [$];

    bit count_on = 0;
    int c_t0 = 0, c_t1 = 0, c_z = 0, c_g = 0, c_l1 = 0;

    logic [15:0] lf0 = 16'hACE1, lf1 = 16'h1D2B, lf2 = 16'h7F31;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int clampi(int x);
        if (x < int'(mem_lo)) return int'(mem_lo);
        if (x > int'(mem_hi)) return int'(mem_hi);
        return x;
    endfunction

    function automatic bit draw(ref logic [15:0] s, input int rate);
        for (int i = 0; i < 8; i++)
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        return (int'(s[7:0]) < rate);
    endfunction

    // Driver: drive one step, advance the model, push the expected spikes.
    task automatic step(input bit l0, input bit l1, input bit g, input bit e, input bit r);
        bit ns [3];
        int a;
        @(negedge clk);
        in_spk = {l1, l0};
        gamma_spk = g;
        en = e;
        rst = r;
        a = int'(step_alpha);
        if (r) begin
            for (int k = 0; k < 3; k++) begin mv[k] = int'(mem_lo); ms[k] = 0; end
        end else if (e) begin
            for (int k = 0; k < 3; k++) ns[k] = (mv[k] >= int'(fire_lvl));
            mv[0] = clampi(mv[0] + a * (int'(l0) - int'(ms[0]) - int'(ms[2])));
            mv[1] = clampi(mv[1] + a * (int'(l1) - int'(ms[1]) - int'(ms[2])));
            mv[2] = clampi(mv[2] + a * (int'(ms[0]) + int'(ms[1]) - int'(g)));
            for (int k = 0; k < 3; k++) ms[k] = ns[k];
        end
        exp_q.push_back({ms[2], ms[1], ms[0]});
        if (count_on) begin
            c_g += int'(g);
            c_l1 += int'(l1);
        end
    endtask

    // Monitor: compare each step's spikes against the scoreboard.
    always @(posedge clk) begin
        logic [2:0] expv;
        logic [2:0] got;
        #1;
        if (exp_q.size() > 0) begin
            expv = exp_q.pop_front();
            got = {z_spk, out_spk[1], out_spk[0]};
            check(got === expv, "R3/R4/R5/R6", "spike vector", int'(got), int'(expv));
            if (count_on) begin
                c_t0 += int'(out_spk[0]);
                c_t1 += int'(out_spk[1]);
                c_z  += int'(z_spk);
            end
        end
    end

    task automatic rate_run(input int r0, input int r1, input int rg, input int z_nom, input int t0_nom);
        int d;
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < 1024; i++)
            step(draw(lf0, r0), draw(lf1, r1), draw(lf2, rg), 1, 0);
        c_t0 = 0; c_t1 = 0; c_z = 0; c_g = 0; c_l1 = 0;
        count_on = 1;
        for (int i = 0; i < 4096; i++)
            step(draw(lf0, r0), draw(lf1, r1), draw(lf2, rg), 1, 0);
        @(posedge clk); #2;
        count_on = 0;
        // R8: input-cell spikes balance the budget count within 2%.
        d = c_t0 + c_t1 - c_g;
        if (d < 0) d = -d;
        check(d * 50 <= c_g, "R8", "T0+T1 vs budget", c_t0 + c_t1, c_g);
        // R9: input-1 cell plus z balances input-1 count within 2%.
        d = c_l1 - (c_t1 + c_z);
        if (d < 0) d = -d;
        check(d * 50 <= c_l1, "R9", "T1+z vs input-1", c_t1 + c_z, c_l1);
        d = c_z - z_nom;
        if (d < 0) d = -d;
        check(d <= 164, "R9", "z count", c_z, z_nom);
        d = c_t0 - t0_nom;
        if (d < 0) d = -d;
        check(d <= 164, "R9", "T0 count", c_t0, t0_nom);
    endtask

    initial begin
        int first;
        logic [2:0] held;
        int any;

        // R1: reset clears spikes.
        step(0, 0, 0, 0, 1);
        step(1, 1, 1, 1, 1);
        @(posedge clk); #2;
        check(out_spk == 2'b00, "R1", "out_spk after reset", int'(out_spk), 0);
        check(z_spk == 1'b0, "R1", "z_spk after reset", int'(z_spk), 0);

        // R7: drive the constraint membrane far below the floor with the budget.
        for (int i = 0; i < 40; i++) step(0, 0, 1, 1, 0);
        first = -1;
        for (int k = 1; k <= 40; k++) begin
            step(1, 0, 0, 1, 0);
            @(posedge clk); #2;
            if (first < 0 && out_spk[0]) first = k;
        end
        // Climb of 16 steps of 8 from -128 to 0, plus the registered decision.
        check(first == 17, "R3/R5", "first T0 step", first, 17);
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < 40; i++) step(0, 0, 1, 1, 0);
        first = -1;
        for (int k = 1; k <= 45; k++) begin
            step(1, 0, 0, 1, 0);
            @(posedge clk); #2;
            if (first < 0 && z_spk) first = k;
        end
        check(first == 34, "R7", "first z step after floor hold", first, 34);

        // R2: freeze with enable low.
        for (int i = 0; i < 30; i++) step(draw(lf0, 200), draw(lf1, 128), draw(lf2, 60), 1, 0);
        @(posedge clk); #2;
        held = {z_spk, out_spk};
        for (int i = 0; i < 10; i++) begin
            step(draw(lf0, 200), draw(lf1, 200), draw(lf2, 200), 0, 0);
            @(posedge clk); #2;
            check({z_spk, out_spk} == held, "R2", "spikes while disabled", int'({z_spk, out_spk}), int'(held));
        end
        for (int i = 0; i < 30; i++) step(draw(lf0, 200), draw(lf1, 128), draw(lf2, 60), 1, 0);

        // R10: zero step size keeps every cell silent.
        step_alpha = 4'd0;
        step(0, 0, 0, 0, 1);
        any = 0;
        for (int i = 0; i < 60; i++) begin
            step(1, 1, 0, 1, 0);
            @(posedge clk); #2;
            any += int'(out_spk[0]) + int'(out_spk[1]) + int'(z_spk);
        end
        check(any == 0, "R10", "spikes with zero step", any, 0);

        // R7: low ceiling that clamps often, checked by the scoreboard.
        step_alpha = 4'd5;
        mem_hi = 12'sd12;
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < 300; i++) step(draw(lf0, 230), draw(lf1, 180), draw(lf2, 40), 1, 0);

        // R8 / R9: rate runs.
        step_alpha = 4'd8;
        mem_lo = -12'sd128;
        mem_hi = 12'sd127;
        fire_lvl = 12'sd0;
        rate_run(51, 128, 77, 819, 0);
        rate_run(77, 128, 77, 1024, 205);

        @(posedge clk); #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule